// File: doc/BRIEF.md
# PoE Port Lifecycle Sequencer

This block runs one power-sourcing port through its whole life: it waits for a valid signature, takes the class result, ramps power through an inrush window, lets the port settle, and then watches it while it carries load. The analog front end and the budget manager sit outside. This block receives their results as single-cycle strobes and levels. From them it drives the port power enable and a power-limit level, and it reports the current state and the most recent cause.

Faults are handled so that a bad port cannot toggle power forever. An over-current or a failed inrush turns power off on the next clock and starts a cooldown. Each such trip uses up one retry. When a trip arrives and no retries are left, the port latches into lockout, and only a management clear releases it. A long enough stretch of healthy operation gives the retries back. Thermal shutdown, loss of the budget grant and surge events each carry their own reason code and do not use up retries. A snapshot of the state a port was in when it dropped is kept for diagnosis.

Top module: `poe_port_seq`

## Requirements
- R1: After reset the state code is 0 (detect), power is off, the power-limit is 0, the reason code is 0 (none) and the surge count is 0. State codes: detect 0, classify 1, power-on 2, maintain 3, monitor 4, fault 5, lockout 6, budget-off 7.
- R2: A detection strobe with a good signature moves detect to classify, and a strobe with a bad signature leaves the port in detect. A class strobe while the grant is high moves to power-on with power enabled and the limit set to the class level.
- R3: Power-on lasts exactly INRUSH_CYC cycles and then becomes maintain. Maintain lasts exactly SETTLE_CYC cycles and then becomes monitor.
- R4: An over-current flag in power-on, maintain or monitor removes power on the next clock, enters fault and sets reason 1. Over-current takes priority over inrush failure, over-temperature and grant loss in the same cycle.
- R5: An inrush-failure flag during power-on enters fault with reason 2 and removes power.
- R6: A fault lasts COOL_CYC cycles and then returns to detect.
- R7: Over-current and inrush trips are counted. A counted trip that arrives after MAX_RETRY counted trips enters lockout (state 6) instead of fault. Lockout ignores every input except the management clear, which returns the port to detect and resets the count. The management clear has no effect in any other state.
- R8: GOOD_RUN_CYC consecutive cycles in monitor reset the trip count to zero.
- R9: While the port is powered and the over-temperature warning is high, the power-limit is at most DERATE_LVL. Otherwise a powered port shows its class level.
- R10: An over-temperature critical flag on a powered port enters fault with reason 3 and does not count as a trip. The port leaves this fault only when the cooldown has elapsed and the warning is low.
- R11: Grant loss on a powered port, or a class strobe without the grant, enters budget-off (state 7) with reason 4 and power off, and does not count as a trip. Budget-off returns to detect when the grant returns.
- R12: A surge strobe increments a saturating surge count and sets reason 5 (unless a fault cause is recorded in the same cycle). It leaves the state and the power unchanged.
- R13: On each entry to fault, lockout or budget-off, the snapshot output holds the state code the port left.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| det_valid | input | 1 | Detection result strobe |
| det_good | input | 1 | Detection signature is valid |
| cls_valid | input | 1 | Class result strobe |
| cls_level | input | CLS_W | Class result level |
| grant | input | 1 | Budget grant from the power manager |
| oc_trip | input | 1 | Over-current or short flag |
| inrush_fail | input | 1 | Inrush phase failed |
| ot_warn | input | 1 | Over-temperature warning (lower threshold) |
| ot_crit | input | 1 | Over-temperature critical (upper threshold) |
| surge_evt | input | 1 | Surge or transient event strobe |
| mgmt_clear | input | 1 | Management lockout clear |
| pwr_en | output | 1 | Port power enable |
| pwr_limit | output | CLS_W | Active power-limit level |
| state_code | output | 3 | Current lifecycle state |
| reason_code | output | 3 | Most recent cause |
| snap_state | output | 3 | State left at the last drop |
| surge_count | output | SURGE_W | Saturating surge event count |

## Verification
The bench builds the block with INRUSH_CYC=4, SETTLE_CYC=3, COOL_CYC=8, GOOD_RUN_CYC=16, MAX_RETRY=2 and SURGE_W=4. These short windows let the bench count every phase boundary cycle by cycle. They also make three counted trips enough to reach lockout, and sixteen surge strobes enough to saturate the surge count. With a 16-cycle healthy window, the bench can run one trip sequence that reaches lockout and another, interrupted by a healthy run, that does not. The bench also uses the retry limit to show that thermal and budget drops leave the count untouched.

// File: rtl/poe_port_pkg.sv
package poe_port_pkg;

  typedef enum logic [2:0] {
    ST_DETECT     = 3'd0,
    ST_CLASSIFY   = 3'd1,
    ST_PWR_ON     = 3'd2,
    ST_MAINTAIN   = 3'd3,
    ST_MONITOR    = 3'd4,
    ST_FAULT      = 3'd5,
    ST_LOCKOUT    = 3'd6,
    ST_BUDGET_OFF = 3'd7
  } port_state_e;

  typedef enum logic [2:0] {
    RSN_NONE        = 3'd0,
    RSN_OVERCURRENT = 3'd1,
    RSN_INRUSH      = 3'd2,
    RSN_THERMAL     = 3'd3,
    RSN_BUDGET      = 3'd4,
    RSN_SURGE       = 3'd5
  } port_reason_e;

  function automatic logic is_powered(port_state_e s);
    return (s == ST_PWR_ON) || (s == ST_MAINTAIN) || (s == ST_MONITOR);
  endfunction

endpackage

// File: rtl/poe_dwell_timer.sv
// Counts cycles since the last restart, saturating at MAX_CNT.
module poe_dwell_timer #(
  parameter int MAX_CNT = 100,
  parameter int W       = $clog2(MAX_CNT + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] SAT = W'(MAX_CNT);

  logic         cnt_en;
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_en = restart || (count != SAT);
    cnt_d  = restart ? '0 : count + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count <= '0;
    else if (cnt_en) count <= cnt_d;
  end

  a_r3_timer_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= SAT);

  a_r3_timer_restart: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> count == '0);
endmodule

// File: rtl/poe_retry_track.sv
// Counts trips that use up a retry; signals when no retries remain.
module poe_retry_track #(
  parameter int MAX_RETRY = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trip_hit,
  input  logic clear,
  output logic exhausted
);
  localparam int RW = $clog2(MAX_RETRY + 1);
  localparam logic [RW-1:0] LIMIT = RW'(MAX_RETRY);

  logic [RW-1:0] cnt_q;
  logic [RW-1:0] cnt_d;
  logic          cnt_en;

  assign exhausted = (cnt_q == LIMIT);

  always_comb begin
    cnt_en = clear || (trip_hit && !exhausted);
    cnt_d  = clear ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  a_r7_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIMIT);

  a_r8_count_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> cnt_q == '0);
endmodule

// File: rtl/poe_port_seq.sv
module poe_port_seq
  import poe_port_pkg::*;
#(
  parameter int INRUSH_CYC   = 1000,
  parameter int SETTLE_CYC   = 200,
  parameter int COOL_CYC     = 50000,
  parameter int GOOD_RUN_CYC = 100000,
  parameter int MAX_RETRY    = 3,
  parameter int CLS_W        = 3,
  parameter int DERATE_LVL   = 2,
  parameter int SURGE_W      = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               det_valid,
  input  logic               det_good,
  input  logic               cls_valid,
  input  logic [CLS_W-1:0]   cls_level,
  input  logic               grant,
  input  logic               oc_trip,
  input  logic               inrush_fail,
  input  logic               ot_warn,
  input  logic               ot_crit,
  input  logic               surge_evt,
  input  logic               mgmt_clear,
  output logic               pwr_en,
  output logic [CLS_W-1:0]   pwr_limit,
  output logic [2:0]         state_code,
  output logic [2:0]         reason_code,
  output logic [2:0]         snap_state,
  output logic [SURGE_W-1:0] surge_count
);
  localparam int M1 = (INRUSH_CYC > SETTLE_CYC) ? INRUSH_CYC : SETTLE_CYC;
  localparam int M2 = (COOL_CYC > GOOD_RUN_CYC) ? COOL_CYC : GOOD_RUN_CYC;
  localparam int DW_MAX = (M1 > M2) ? M1 : M2;
  localparam int DW = $clog2(DW_MAX + 1);
  localparam logic [DW-1:0] INRUSH_LAST = DW'(INRUSH_CYC - 1);
  localparam logic [DW-1:0] SETTLE_LAST = DW'(SETTLE_CYC - 1);
  localparam logic [DW-1:0] COOL_LAST   = DW'(COOL_CYC - 1);
  localparam logic [DW-1:0] GOOD_LAST   = DW'(GOOD_RUN_CYC - 1);
  localparam logic [CLS_W-1:0] DERATE   = CLS_W'(DERATE_LVL);
  localparam logic [SURGE_W-1:0] SURGE_SAT = '1;

  port_state_e        state_q, state_d;
  port_reason_e       reason_q, cause;
  port_state_e        snap_q;
  logic [CLS_W-1:0]   class_q;
  logic [SURGE_W-1:0] surge_q;
  logic               therm_q, thermal_set;
  logic               counted, exhausted, good_run, retry_clear;
  logic               powered;
  logic [DW-1:0]      dwell;

  assign powered = is_powered(state_q);

  poe_dwell_timer #(.MAX_CNT(DW_MAX), .W(DW)) u_dwell (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (state_d != state_q),
    .count   (dwell)
  );

  assign good_run    = (state_q == ST_MONITOR) && (dwell == GOOD_LAST);
  assign retry_clear = good_run || ((state_q == ST_LOCKOUT) && mgmt_clear);

  poe_retry_track #(.MAX_RETRY(MAX_RETRY)) u_retry (
    .clk       (clk),
    .rst_n     (rst_n),
    .trip_hit  (counted),
    .clear     (retry_clear),
    .exhausted (exhausted)
  );

  // Next-state and cause selection
  always_comb begin
    state_d     = state_q;
    cause       = RSN_NONE;
    counted     = 1'b0;
    thermal_set = 1'b0;
    case (state_q)
      ST_DETECT:
        if (det_valid && det_good) state_d = ST_CLASSIFY;
      ST_CLASSIFY:
        if (cls_valid) begin
          if (grant) state_d = ST_PWR_ON;
          else begin
            state_d = ST_BUDGET_OFF;
            cause   = RSN_BUDGET;
          end
        end
      ST_PWR_ON, ST_MAINTAIN, ST_MONITOR: begin
        if (oc_trip) begin
          cause   = RSN_OVERCURRENT;
          counted = 1'b1;
        end else if ((state_q == ST_PWR_ON) && inrush_fail) begin
          cause   = RSN_INRUSH;
          counted = 1'b1;
        end else if (ot_crit) begin
          cause       = RSN_THERMAL;
          thermal_set = 1'b1;
          state_d     = ST_FAULT;
        end else if (!grant) begin
          cause   = RSN_BUDGET;
          state_d = ST_BUDGET_OFF;
        end else if ((state_q == ST_PWR_ON) && (dwell == INRUSH_LAST)) begin
          state_d = ST_MAINTAIN;
        end else if ((state_q == ST_MAINTAIN) && (dwell == SETTLE_LAST)) begin
          state_d = ST_MONITOR;
        end
        if (counted) state_d = exhausted ? ST_LOCKOUT : ST_FAULT;
      end
      ST_FAULT:
        if ((dwell >= COOL_LAST) && !(therm_q && ot_warn)) state_d = ST_DETECT;
      ST_LOCKOUT:
        if (mgmt_clear) state_d = ST_DETECT;
      ST_BUDGET_OFF:
        if (grant) state_d = ST_DETECT;
      default: state_d = ST_DETECT;
    endcase
  end

  // Register process with explicit enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_DETECT;
      reason_q <= RSN_NONE;
      snap_q   <= ST_DETECT;
      class_q  <= '0;
      surge_q  <= '0;
      therm_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (cause != RSN_NONE) begin
        reason_q <= cause;
        snap_q   <= state_q;
      end else if (surge_evt) begin
        reason_q <= RSN_SURGE;
      end
      if ((state_q == ST_CLASSIFY) && cls_valid) class_q <= cls_level;
      if (surge_evt && (surge_q != SURGE_SAT)) surge_q <= surge_q + 1'b1;
      if ((state_d == ST_FAULT) && (state_q != ST_FAULT)) therm_q <= thermal_set;
    end
  end

  always_comb begin
    pwr_en      = powered;
    pwr_limit   = '0;
    if (powered) pwr_limit = (ot_warn && (class_q > DERATE)) ? DERATE : class_q;
    state_code  = state_q;
    reason_code = reason_q;
    snap_state  = snap_q;
    surge_count = surge_q;
  end

  a_r4_oc_trip_off: assert property (@(posedge clk) disable iff (!rst_n)
    (powered && oc_trip) |=> (!pwr_en && reason_q == RSN_OVERCURRENT &&
                              (state_q == ST_FAULT || state_q == ST_LOCKOUT)));

  a_r6_cooldown_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FAULT && dwell < COOL_LAST) |=> state_q == ST_FAULT);

  a_r7_lockout_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LOCKOUT && !mgmt_clear) |=> state_q == ST_LOCKOUT);

  a_r9_derate_cap: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_en && ot_warn) |-> pwr_limit <= DERATE);

  a_r10_thermal_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FAULT && therm_q && ot_warn) |=> state_q == ST_FAULT);

  a_r11_budget_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (powered && !grant && !oc_trip && !ot_crit &&
     !(state_q == ST_PWR_ON && inrush_fail)) |=> state_q == ST_BUDGET_OFF);

  a_r12_surge_count: assert property (@(posedge clk) disable iff (!rst_n)
    (surge_evt && surge_q != SURGE_SAT) |=> surge_q == $past(surge_q) + 1'b1);

  a_r12_surge_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
    (surge_evt && state_q == ST_MONITOR && grant && !oc_trip && !ot_crit &&
     dwell != GOOD_LAST) |=> state_q == ST_MONITOR);
endmodule

// File: tb/tb_poe_port_seq.sv
module tb_poe_port_seq;
  localparam int CLS_W = 3;
  localparam int SURGE_W = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic det_valid, det_good, cls_valid, grant, oc_trip, inrush_fail;
  logic ot_warn, ot_crit, surge_evt, mgmt_clear;
  logic [CLS_W-1:0] cls_level;
  logic pwr_en;
  logic [CLS_W-1:0] pwr_limit;
  logic [2:0] state_code, reason_code, snap_state;
  logic [SURGE_W-1:0] surge_count;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  poe_port_seq #(
    .INRUSH_CYC(4), .SETTLE_CYC(3), .COOL_CYC(8), .GOOD_RUN_CYC(16),
    .MAX_RETRY(2), .CLS_W(CLS_W), .DERATE_LVL(2), .SURGE_W(SURGE_W)
  ) dut (
    .clk(clk), .rst_n(rst_n), .det_valid(det_valid), .det_good(det_good),
    .cls_valid(cls_valid), .cls_level(cls_level), .grant(grant),
    .oc_trip(oc_trip), .inrush_fail(inrush_fail), .ot_warn(ot_warn),
    .ot_crit(ot_crit), .surge_evt(surge_evt), .mgmt_clear(mgmt_clear),
    .pwr_en(pwr_en), .pwr_limit(pwr_limit), .state_code(state_code),
    .reason_code(reason_code), .snap_state(snap_state), .surge_count(surge_count)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; det_valid = 0; det_good = 0; cls_valid = 0; cls_level = 0;
    grant = 1; oc_trip = 0; inrush_fail = 0; ot_warn = 0; ot_crit = 0;
    surge_evt = 0; mgmt_clear = 0;
    step(2);
    rst_n = 1'b1;
    step(1);
  endtask

  task automatic to_pwr_on(int cls);
    det_valid = 1; det_good = 1; step(1); det_valid = 0;
    check("R2 classify", state_code, 1);
    cls_valid = 1; cls_level = CLS_W'(cls); step(1); cls_valid = 0;
    check("R2 power-on", state_code, 2);
    check("R2 pwr_en", pwr_en, 1);
    check("R2 limit", pwr_limit, cls);
  endtask

  task automatic to_monitor(int cls);
    to_pwr_on(cls);
    step(3); check("R3 inrush hold", state_code, 2);
    step(1); check("R3 maintain", state_code, 3);
    step(2); check("R3 settle hold", state_code, 3);
    step(1); check("R3 monitor", state_code, 4);
  endtask

  task automatic oc_pulse();
    oc_trip = 1; step(1); oc_trip = 0;
  endtask

  task automatic wait_cool();
    step(7); check("R6 cooldown hold", state_code, 5);
    step(1); check("R6 back to detect", state_code, 0);
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 state", state_code, 0);
    check("R1 pwr_en", pwr_en, 0);
    check("R1 limit", pwr_limit, 0);
    check("R1 reason", reason_code, 0);
    check("R1 surge", surge_count, 0);
  endtask

  task automatic t_detect();
    do_reset();
    det_valid = 1; det_good = 0; step(1); det_valid = 0;
    check("R2 bad signature stays", state_code, 0);
    mgmt_clear = 1; step(1); mgmt_clear = 0;
    check("R7 clear ignored outside lockout", state_code, 0);
    to_monitor(5);
    check("R2 monitor powered", pwr_en, 1);
  endtask

  task automatic t_derate_surge();
    do_reset();
    to_monitor(5);
    ot_warn = 1; step(1);
    check("R9 derated limit", pwr_limit, 2);
    ot_warn = 0; step(1);
    check("R9 class limit restored", pwr_limit, 5);
    surge_evt = 1; step(1); surge_evt = 0;
    check("R12 state kept", state_code, 4);
    check("R12 power kept", pwr_en, 1);
    check("R12 reason surge", reason_code, 5);
    check("R12 count one", surge_count, 1);
    surge_evt = 1; step(20); surge_evt = 0;
    check("R12 saturates", surge_count, 15);
  endtask

  task automatic t_oc();
    do_reset();
    to_monitor(4);
    oc_trip = 1; ot_crit = 1; grant = 0; step(1);
    oc_trip = 0; ot_crit = 0; grant = 1;
    check("R4 fault", state_code, 5);
    check("R4 power off", pwr_en, 0);
    check("R4 priority reason", reason_code, 1);
    check("R13 snapshot monitor", snap_state, 4);
    wait_cool();
  endtask

  task automatic t_lockout();
    do_reset();
    to_monitor(3); oc_pulse();
    check("R7 first trip fault", state_code, 5);
    wait_cool();
    to_pwr_on(3);
    inrush_fail = 1; step(1); inrush_fail = 0;
    check("R5 inrush fault", state_code, 5);
    check("R5 reason", reason_code, 2);
    check("R5 power off", pwr_en, 0);
    check("R13 snapshot power-on", snap_state, 2);
    wait_cool();
    to_monitor(3); oc_pulse();
    check("R7 lockout", state_code, 6);
    check("R7 power off", pwr_en, 0);
    check("R13 snapshot", snap_state, 4);
    det_valid = 1; det_good = 1; step(20); det_valid = 0;
    check("R7 lockout held", state_code, 6);
    mgmt_clear = 1; step(1); mgmt_clear = 0;
    check("R7 cleared", state_code, 0);
    to_monitor(3); oc_pulse();
    check("R7 count reset by clear", state_code, 5);
  endtask

  task automatic t_goodrun();
    do_reset();
    to_monitor(3); oc_pulse(); wait_cool();
    to_monitor(3); oc_pulse(); wait_cool();
    to_monitor(3); step(20); oc_pulse();
    check("R8 good run restores retries", state_code, 5);
  endtask

  task automatic t_thermal();
    do_reset();
    to_monitor(6);
    ot_crit = 1; ot_warn = 1; step(1); ot_crit = 0;
    check("R10 thermal fault", state_code, 5);
    check("R10 reason", reason_code, 3);
    step(12);
    check("R10 held while warm", state_code, 5);
    ot_warn = 0; step(1);
    check("R10 recovered", state_code, 0);
    to_monitor(6); oc_pulse(); wait_cool();
    to_monitor(6); oc_pulse();
    check("R10 thermal not counted", state_code, 5);
  endtask

  task automatic t_budget();
    do_reset();
    for (int i = 0; i < 3; i++) begin
      to_monitor(2);
      grant = 0; step(1);
      check("R11 budget off", state_code, 7);
      check("R11 reason", reason_code, 4);
      check("R11 power off", pwr_en, 0);
      step(3);
      check("R11 held without grant", state_code, 7);
      grant = 1; step(1);
      check("R11 back to detect", state_code, 0);
    end
    to_monitor(2); oc_pulse();
    check("R11 drops not counted", state_code, 5);
    wait_cool();
    det_valid = 1; det_good = 1; step(1); det_valid = 0;
    grant = 0; cls_valid = 1; cls_level = 3; step(1); cls_valid = 0;
    check("R11 class without grant", state_code, 7);
    check("R13 snapshot classify", snap_state, 1);
    grant = 1; step(1);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000 && !done) begin
        done = 1'b1;
        errors++;
        $display("FAIL watchdog actual %0d expected below 100000", cycles);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    t_reset();
    t_detect();
    t_derate_surge();
    t_oc();
    t_lockout();
    t_goodrun();
    t_thermal();
    t_budget();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule